// File: doc/BRIEF.md
# Cache Line-Fill Buffer

This block sits between a cache's miss handling and its tag and data arrays. When the cache allocates a line, the block is armed with the line address and the way chosen for replacement. It then collects the burst read response from the bus, four longwords in ascending order, and holds them until the line is complete. Only then does it issue one write that installs tag, data and a set valid bit into the arrays. A partial line never reaches the arrays.

While the refill is outstanding the cache keeps working. A processor access that hits another line in the arrays proceeds. A read to the line being refilled is answered from the buffer as soon as its longword has arrived. A read of a word that has not arrived stalls, and so do a write to that line and a miss to any other line. A bus error during the burst throws the collected words away, leaves the line uninstalled and raises an error pulse toward the requester. The same block serves both the instruction cache and the data cache. The instruction side simply never asserts the write request.

Top module: `lineFillBuf`

## Requirements
- R1: After reset `fillBusy`, `fillErr`, `lineWrValid`, `reqStall` and `fwdValid` are all 0.
- R2: A `fillStart` accepted while idle latches the line address and the way. `fillBusy` is 1 from the next cycle. Beats (`busValid`=1) fill longwords 0,1,2,3 in that order, with `busLast` set only on the fourth beat.
- R3: `lineWrValid` is 1 for exactly one cycle, the cycle after the fourth beat. It is never 1 before that beat. `fillBusy` is 0 in the following cycle.
- R4: In that write cycle `lineWrIndex` = address bits [11:4] and `lineWrTag` = bits [31:12] of the latched address. `lineWrWay` is the latched way. `lineWrData` holds longword k in bits [32k+31:32k].
- R5: While busy, a read (`reqWrite`=0) whose address bits [31:4] match the filling line and whose word (bits [3:2]) has arrived gives `fwdValid`=1, `fwdData` = that word and `reqStall`=0, all in the same cycle.
- R6: While busy, a read to the filling line whose word has not yet arrived gives `reqStall`=1 and `fwdValid`=0.
- R7: While busy, a write to the filling line gives `reqStall`=1 and `fwdValid`=0, whatever words have arrived.
- R8: While busy, an access to another line with `reqHitArray`=1 gives `reqStall`=0 and `fwdValid`=0. With `reqHitArray`=0 it gives `reqStall`=1.
- R9: A beat with `busErr`=1 ends the fill. In the next cycle `fillErr` is 1 for one cycle, no `lineWrValid` follows, and reads to that line stall. One cycle later the block is idle.
- R10: A `fillStart` while busy is ignored. The line write still carries the first address and way.
- R11: While idle, no access stalls or is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillStart | input | 1 | Arm a refill for `fillAddr`/`fillWay` |
| fillAddr | input | 32 | Byte address inside the line to refill |
| fillWay | input | 2 | Replacement way for the refill |
| busValid | input | 1 | Burst beat present |
| busData | input | 32 | Beat longword |
| busLast | input | 1 | Final beat of the burst |
| busErr | input | 1 | Beat carries a bus error |
| reqValid | input | 1 | Processor access present |
| reqWrite | input | 1 | Access is a write |
| reqAddr | input | 32 | Access byte address |
| reqHitArray | input | 1 | Access hits a valid line in the arrays |
| reqStall | output | 1 | Access must wait |
| fwdValid | output | 1 | Access answered from the buffer |
| fwdData | output | 32 | Forwarded longword |
| fillBusy | output | 1 | A refill is outstanding |
| fillErr | output | 1 | Refill aborted by a bus error |
| lineWrValid | output | 1 | Install the completed line |
| lineWrIndex | output | 8 | Set index of the line write |
| lineWrTag | output | 20 | Tag of the line write |
| lineWrWay | output | 2 | Way of the line write |
| lineWrData | output | 128 | Four longwords of the line |

## Verification
The embedded properties check on every cycle that a line write needs a full arrival mask and a beat in the cycle before it. They also check that each accepted beat adds exactly one word, that the last flag lines up with the fourth beat, that an error pulse follows an erroring beat, and that stalls and forwards only happen while busy. The bench scenarios are the only place where data values show up. They cover word-by-word forwarding as each longword arrives, the split between stalling and non-stalling accesses to other lines, writes to the filling line, the ignored second start, and an abort at each of the four beat positions.

// File: rtl/lfbPkg.sv
package lfbPkg;
  typedef struct packed {
    logic capture;
    logic load;
    logic discard;
  } fillStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FAULT = 2'd3
  } fillStateT;
endpackage

// File: rtl/lfbCtrl.sv
module lfbCtrl
  import lfbPkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fillStart,
  input  logic                       busValid,
  input  logic                       busLast,
  input  logic                       busErr,
  output fillStrobeT                 strobes,
  output logic [$clog2(WORDS)-1:0]   wordSel,
  output logic                       busy,
  output logic                       lineWr,
  output logic                       faultPulse
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  fillStateT state, stateNext;
  logic [WSEL_W-1:0] beatCnt;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (fillStart) begin
        strobes.capture = 1'b1;
        stateNext       = ST_FILL;
      end
      ST_FILL: if (busValid) begin
        if (busErr) begin
          strobes.discard = 1'b1;
          stateNext       = ST_FAULT;
        end else begin
          strobes.load = 1'b1;
          if (beatCnt == LAST_BEAT) stateNext = ST_WRITE;
        end
      end
      ST_WRITE: stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.capture)   beatCnt <= '0;
      else if (strobes.load) beatCnt <= beatCnt + 1'b1;
    end
  end

  assign wordSel    = beatCnt;
  assign busy       = (state != ST_IDLE);
  assign lineWr     = (state == ST_WRITE);
  assign faultPulse = (state == ST_FAULT);

  assert_last_on_final_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && busValid && !busErr) |-> (busLast == (beatCnt == LAST_BEAT)));

  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineWr |=> !lineWr && !busy);
endmodule

// File: rtl/lfbDatapath.sv
module lfbDatapath
  import lfbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 256,
  parameter int WAYS   = 4
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  fillStrobeT                                   strobes,
  input  logic [$clog2(WORDS)-1:0]                     wordSel,
  input  logic                                         busy,
  input  logic                                         lineWr,
  input  logic [ADDR_W-1:0]                            fillAddr,
  input  logic [$clog2(WAYS)-1:0]                      fillWay,
  input  logic [WORD_W-1:0]                            busData,
  input  logic                                         reqValid,
  input  logic                                         reqWrite,
  input  logic [ADDR_W-1:0]                            reqAddr,
  input  logic                                         reqHitArray,
  output logic                                         reqStall,
  output logic                                         fwdValid,
  output logic [WORD_W-1:0]                            fwdData,
  output logic [$clog2(SETS)-1:0]                      lineWrIndex,
  output logic [ADDR_W-$clog2(WORDS*WORD_W/8)-$clog2(SETS)-1:0] lineWrTag,
  output logic [$clog2(WAYS)-1:0]                      lineWrWay,
  output logic [WORDS*WORD_W-1:0]                      lineWrData
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);

  logic [LINE_W-1:0] lineAddr;
  logic [WAY_W-1:0]  wayReg;
  logic [WORD_W-1:0] lineBuf [WORDS];
  logic [WORDS-1:0]  wordMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddr <= '0;
      wayReg   <= '0;
      wordMask <= '0;
      for (int i = 0; i < WORDS; i++) lineBuf[i] <= '0;
    end else begin
      if (strobes.capture) begin
        lineAddr <= fillAddr[ADDR_W-1:OFF_W];
        wayReg   <= fillWay;
        wordMask <= '0;
      end
      if (strobes.load) begin
        lineBuf[wordSel]  <= busData;
        wordMask[wordSel] <= 1'b1;
      end
      if (strobes.discard) wordMask <= '0;
    end
  end

  logic              sameLine;
  logic [WSEL_W-1:0] reqWord;
  logic              wordHere;

  assign sameLine = (reqAddr[ADDR_W-1:OFF_W] == lineAddr);
  assign reqWord  = reqAddr[BYTE_W +: WSEL_W];
  assign wordHere = wordMask[reqWord];

  always_comb begin
    reqStall = 1'b0;
    fwdValid = 1'b0;
    if (busy && reqValid) begin
      if (sameLine) begin
        fwdValid = !reqWrite && wordHere;
        reqStall = reqWrite || !wordHere;
      end else begin
        reqStall = !reqHitArray;
      end
    end
  end

  assign fwdData = lineBuf[reqWord];

  for (genvar w = 0; w < WORDS; w++) begin : gPack
    assign lineWrData[w*WORD_W +: WORD_W] = lineBuf[w];
  end

  assign lineWrIndex = lineAddr[IDX_W-1:0];
  assign lineWrTag   = lineAddr[LINE_W-1:IDX_W];
  assign lineWrWay   = wayReg;

  logic unusedLowBits;
  assign unusedLowBits = ^{reqAddr[BYTE_W-1:0], fillAddr[OFF_W-1:0], TAG_W[0]};

  assert_full_before_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineWr |-> (&wordMask));

  assert_one_word_per_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> ($countones(wordMask) == $past($countones(wordMask)) + 1));

  assert_discard_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.discard |=> (wordMask == '0));
endmodule

// File: rtl/lineFillBuf.sv
module lineFillBuf
  import lfbPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 256,
  parameter int WAYS   = 4
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         fillStart,
  input  logic [ADDR_W-1:0]                            fillAddr,
  input  logic [$clog2(WAYS)-1:0]                      fillWay,
  input  logic                                         busValid,
  input  logic [WORD_W-1:0]                            busData,
  input  logic                                         busLast,
  input  logic                                         busErr,
  input  logic                                         reqValid,
  input  logic                                         reqWrite,
  input  logic [ADDR_W-1:0]                            reqAddr,
  input  logic                                         reqHitArray,
  output logic                                         reqStall,
  output logic                                         fwdValid,
  output logic [WORD_W-1:0]                            fwdData,
  output logic                                         fillBusy,
  output logic                                         fillErr,
  output logic                                         lineWrValid,
  output logic [$clog2(SETS)-1:0]                      lineWrIndex,
  output logic [ADDR_W-$clog2(WORDS*WORD_W/8)-$clog2(SETS)-1:0] lineWrTag,
  output logic [$clog2(WAYS)-1:0]                      lineWrWay,
  output logic [WORDS*WORD_W-1:0]                      lineWrData
);
  fillStrobeT                 strobes;
  logic [$clog2(WORDS)-1:0]   wordSel;

  lfbCtrl #(.WORDS(WORDS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fillStart  (fillStart),
    .busValid   (busValid),
    .busLast    (busLast),
    .busErr     (busErr),
    .strobes    (strobes),
    .wordSel    (wordSel),
    .busy       (fillBusy),
    .lineWr     (lineWrValid),
    .faultPulse (fillErr)
  );

  lfbDatapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS), .WAYS(WAYS)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wordSel     (wordSel),
    .busy        (fillBusy),
    .lineWr      (lineWrValid),
    .fillAddr    (fillAddr),
    .fillWay     (fillWay),
    .busData     (busData),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqHitArray (reqHitArray),
    .reqStall    (reqStall),
    .fwdValid    (fwdValid),
    .fwdData     (fwdData),
    .lineWrIndex (lineWrIndex),
    .lineWrTag   (lineWrTag),
    .lineWrWay   (lineWrWay),
    .lineWrData  (lineWrData)
  );

  assert_write_follows_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineWrValid |-> $past(busValid && !busErr));

  assert_err_follows_bus_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillErr |-> $past(busValid && busErr));

  assert_idle_no_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqStall || fwdValid) |-> (fillBusy && reqValid));

  assert_no_fwd_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> !fwdValid);
endmodule

// File: tb/sim_lineFillBuf.sv
module sim_lineFillBuf;
  logic         clk = 1'b0;
  logic         rstN;
  logic         fillStart;
  logic [31:0]  fillAddr;
  logic [1:0]   fillWay;
  logic         busValid;
  logic [31:0]  busData;
  logic         busLast;
  logic         busErr;
  logic         reqValid;
  logic         reqWrite;
  logic [31:0]  reqAddr;
  logic         reqHitArray;
  logic         reqStall;
  logic         fwdValid;
  logic [31:0]  fwdData;
  logic         fillBusy;
  logic         fillErr;
  logic         lineWrValid;
  logic [7:0]   lineWrIndex;
  logic [19:0]  lineWrTag;
  logic [1:0]   lineWrWay;
  logic [127:0] lineWrData;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lineFillBuf u0 (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lineBase(input int i);
    logic [19:0] tg = 20'hABC00 + 20'(i * 37);
    logic [7:0]  ix = 8'((i * 53) & 255);
    return {tg, ix, 4'h0};
  endfunction

  function automatic logic [31:0] wordVal(input int i, input int w);
    return (32'h1000_0000 * 32'(i + 1)) ^ (32'h0001_0203 * 32'(w + 3)) ^ 32'(w * 7);
  endfunction

  task automatic probe(input logic wr, input logic [31:0] a, input logic hit);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqHitArray = hit;
    #1;
  endtask

  task automatic sweep(input int i, input logic [3:0] arrived);
    logic [31:0] base = lineBase(i);
    for (int w = 0; w < 4; w++) begin
      probe(1'b0, base + 32'(w * 4), 1'b0);
      chk("R2 busy during fill", 128'(fillBusy), 128'(1));
      chk("R3 no early line write", 128'(lineWrValid), 128'(0));
      if (arrived[w]) begin
        chk("R5 fwdValid", 128'(fwdValid), 128'(1));
        chk("R5 fwdData", 128'(fwdData), 128'(wordVal(i, w)));
        chk("R5 no stall", 128'(reqStall), 128'(0));
      end else begin
        chk("R6 stall", 128'(reqStall), 128'(1));
        chk("R6 no fwd", 128'(fwdValid), 128'(0));
      end
    end
    probe(1'b1, base + 32'(i % 4) * 4, 1'b0);
    chk("R7 write stall", 128'(reqStall), 128'(1));
    chk("R7 write no fwd", 128'(fwdValid), 128'(0));
    probe(1'b0, base + 32'h10, 1'b1);
    chk("R8 hit under fill", 128'(reqStall), 128'(0));
    chk("R8 hit no fwd", 128'(fwdValid), 128'(0));
    probe(1'b1, base + 32'h2000_0000, 1'b0);
    chk("R8 miss stalls", 128'(reqStall), 128'(1));
    reqValid = 1'b0;
  endtask

  task automatic beat(input int i, input int w, input logic err);
    @(negedge clk);
    reqValid = 1'b0;
    busValid = 1'b1; busData = wordVal(i, w); busLast = (w == 3); busErr = err;
    @(posedge clk); #1;
    busValid = 1'b0; busLast = 1'b0; busErr = 1'b0;
  endtask

  task automatic startFill(input logic [31:0] a, input logic [1:0] way);
    @(negedge clk);
    fillStart = 1'b1; fillAddr = a; fillWay = way;
    @(posedge clk); #1;
    fillStart = 1'b0;
  endtask

  task automatic runFill(input int i, input int errBeat, input bit stray);
    logic [3:0] arrived = '0;
    logic [31:0] base = lineBase(i);
    logic [1:0] way = 2'(i + 1);
    logic [127:0] expLine;
    startFill(base + 32'(i % 16), way);
    for (int b = 0; b < 4; b++) begin
      for (int g = 0; g < i % 3; g++) @(negedge clk);
      sweep(i, arrived);
      if (stray && b == 1) startFill(lineBase(i + 40), ~way);
      beat(i, b, b == errBeat);
      if (b == errBeat) begin
        @(negedge clk);
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = base; reqHitArray = 1'b0;
        #1;
        chk("R9 error pulse", 128'(fillErr), 128'(1));
        chk("R9 no line write", 128'(lineWrValid), 128'(0));
        chk("R9 discarded word stalls", 128'(reqStall), 128'(1));
        chk("R9 discarded no fwd", 128'(fwdValid), 128'(0));
        reqValid = 1'b0;
        @(negedge clk); #1;
        chk("R9 error one cycle", 128'(fillErr), 128'(0));
        chk("R9 idle after error", 128'(fillBusy), 128'(0));
        chk("R9 still no write", 128'(lineWrValid), 128'(0));
        return;
      end
      arrived[b] = 1'b1;
    end
    @(negedge clk); #1;
    for (int w = 0; w < 4; w++) expLine[w*32 +: 32] = wordVal(i, w);
    chk("R3 line write pulse", 128'(lineWrValid), 128'(1));
    chk("R4 index", 128'(lineWrIndex), 128'(base[11:4]));
    chk(stray ? "R10 tag kept" : "R4 tag", 128'(lineWrTag), 128'(base[31:12]));
    chk(stray ? "R10 way kept" : "R4 way", 128'(lineWrWay), 128'(way));
    chk("R4 data", lineWrData, expLine);
    @(negedge clk); #1;
    chk("R3 pulse ends", 128'(lineWrValid), 128'(0));
    chk("R3 idle after write", 128'(fillBusy), 128'(0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; fillStart = 1'b0; fillAddr = '0; fillWay = '0;
    busValid = 1'b0; busData = '0; busLast = 1'b0; busErr = 1'b0;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqHitArray = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 busy", 128'(fillBusy), 128'(0));
    chk("R1 err", 128'(fillErr), 128'(0));
    chk("R1 line write", 128'(lineWrValid), 128'(0));
    chk("R1 stall", 128'(reqStall), 128'(0));
    chk("R1 fwd", 128'(fwdValid), 128'(0));
    for (int k = 0; k < 4; k++) begin
      probe(k[0], lineBase(0) + 32'(k * 4), 1'b0);
      chk("R11 idle no stall", 128'(reqStall), 128'(0));
      chk("R11 idle no fwd", 128'(fwdValid), 128'(0));
    end
    reqValid = 1'b0;
    for (int i = 0; i < 8; i++)
      runFill(i, (i >= 4) ? i - 4 : -1, i == 2);
    @(negedge clk); #1;
    chk("R11 final idle", 128'(fillBusy), 128'(0));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule